// File: doc/BRIEF.md
# Dual-Channel Match/Compare Timer

This block is a register-mapped timer with two independent 16-bit counting channels. The two channels share a bank of six compare values and one interrupt unit. Each channel has a loadable count, a prescale divider and a control word. The control word selects run or halt, the count direction and the terminal behaviour. The terminal behaviour is one of three: stop at zero, stop on a chosen shared compare value, or wrap without end.

When a channel reaches its chosen compare value, it latches a sticky event flag for that compare slot. The flags are cleared by writing ones. Each flag is gated by an enable bit, and the gated flags are ORed into one level interrupt.

Software uses a single-cycle write strobe and a combinational read port. A select input chooses between the timer space (channel groups and the compare bank) and the interrupt space (flags and enables).

Top module: `dual_match_timer`

## Requirements
- R1: After reset, both control words read 0x10 (halted, counting down, stop-at-zero), counts and dividers read 0, the event flags and enables read 0, and `irq` is low.
- R2: With `reg_irq_sel`=0, channel c uses three byte offsets: count at 0x0C*c, divider at 0x0C*c+4, control at 0x0C*c+8. Compare slot n is at 0x18+4*n. With `reg_irq_sel`=1, the event flags are at 0x00 and the enables at 0x04. Each written value reads back at its offset; count, divider and compare values are 16 bits wide.
- R3: Control bit 4 set halts the channel, and a halted channel's count does not change unless software writes it.
- R4: Control bit 3 set makes a running channel count up; clear makes it count down.
- R5: With divider value D, a running channel steps once every D+1 clocks. The first step falls D+1 clocks after the clock edge that wrote the control word, count or divider.
- R6: Mode field bits [2:0] = 0: when a down-counting channel reaches 0, the channel sets its halt bit (control reads with bit 4 set) and holds 0.
- R7: Mode values 1 to 6 select compare slot (mode−1). When a step lands on that slot's value, event flag bit (mode−1) is set and the channel sets its halt bit.
- R8: Mode 7 never halts and wraps modulo 2^16 in both directions.
- R9: Writing 1s to the flag offset clears those flags. A 0 bit leaves its flag unchanged, and flags stay set while their enable is 0.
- R10: `irq` is high exactly when some flag and its enable bit are both 1.
- R11: An event arriving in the same cycle as a write-1 clear of its flag leaves the flag set.
- R12: A software write to a count or control word takes precedence over the hardware step or halt in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_irq_sel | input | 1 | 1 selects the interrupt space, 0 the timer space |
| reg_addr | input | 6 | Byte offset within the selected space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt: OR of enabled event flags |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a channel's compare hit and a software clear of the same flag share a cycle. The bench provokes this by starting a down-count a known number of steps above the compare value and issuing the clear on exactly the arrival edge; the flag must survive. In the second, a hardware halt or step coincides with a software write to the control word or the count. The bench times those writes to the same edge and judges that the written value wins. A behavioural model compares the read port and `irq` on every clock.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    TERM_ZERO  = 2'd0,
    TERM_MATCH = 2'd1,
    TERM_FREE  = 2'd2
  } term_kind_e;

  // Mode 0 stops at zero, 1..n_match pick a compare slot, anything above wraps.
  function automatic term_kind_e classify_mode(input int mode, input int n_match);
    if (mode == 0)            return TERM_ZERO;
    else if (mode <= n_match) return TERM_MATCH;
    else                      return TERM_FREE;
  endfunction

endpackage

// File: rtl/mct_channel.sv
module mct_channel #(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 16,
  parameter int N_MATCH = 6,
  parameter int MODE_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_cnt,
  input  logic                            wr_div,
  input  logic                            wr_ctl,
  input  logic [CNT_W-1:0]                wval_cnt,
  input  logic [DIV_W-1:0]                wval_div,
  input  logic                            wval_halt,
  input  logic                            wval_up,
  input  logic [MODE_W-1:0]               wval_mode,
  input  logic [N_MATCH-1:0][CNT_W-1:0]   cmp_bank,
  output logic [CNT_W-1:0]                cnt,
  output logic [DIV_W-1:0]                div,
  output logic                            halted,
  output logic                            count_up,
  output logic [MODE_W-1:0]               mode,
  output logic [N_MATCH-1:0]              match_evt
);
  import mct_pkg::*;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] v, input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic logic [DIV_W-1:0] next_prescale(input logic [DIV_W-1:0] p, input logic clr);
    return clr ? '0 : p + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q, pre_q;
  logic             halt_q, up_q;
  logic [MODE_W-1:0] mode_q;

  logic             run, tick, zero_hold, advance, hit_zero, hit_match, hw_halt, any_wr;
  logic [CNT_W-1:0] step_val, sel_cmp;
  term_kind_e       kind;

  assign run      = !halt_q;
  assign tick     = run && (pre_q == div_q);
  assign step_val = next_count(cnt_q, up_q);
  assign kind     = classify_mode(int'(mode_q), N_MATCH);
  assign any_wr   = wr_cnt || wr_div || wr_ctl;

  always_comb begin
    sel_cmp = '0;
    for (int i = 0; i < N_MATCH; i++)
      if (mode_q == MODE_W'(i + 1)) sel_cmp = cmp_bank[i];
  end

  assign zero_hold = tick && (kind == TERM_ZERO) && (cnt_q == '0);
  assign advance   = tick && !zero_hold;
  assign hit_zero  = advance && (kind == TERM_ZERO) && (step_val == '0);
  assign hit_match = advance && (kind == TERM_MATCH) && (step_val == sel_cmp);
  assign hw_halt   = zero_hold || hit_zero || hit_match;

  for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_evt
    assign match_evt[gi] = hit_match && (mode_q == MODE_W'(gi + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= '0;
      pre_q  <= '0;
      halt_q <= 1'b1;
      up_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      if (wr_cnt)       cnt_q <= wval_cnt;
      else if (advance) cnt_q <= step_val;
      if (wr_div) div_q <= wval_div;
      if (wr_ctl) begin
        halt_q <= wval_halt;
        up_q   <= wval_up;
        mode_q <= wval_mode;
      end else if (hw_halt) begin
        halt_q <= 1'b1;
      end
      pre_q <= next_prescale(pre_q, !run || tick || any_wr);
    end
  end

  assign cnt      = cnt_q;
  assign div      = div_q;
  assign halted   = halt_q;
  assign count_up = up_q;
  assign mode     = mode_q;

  // R3: a halted count only moves through a software load
  assert_hold_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_cnt) |=> $stable(cnt_q));

  // R5: each step really moves the count
  assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_cnt) |=> (cnt_q != $past(cnt_q)));

  // R5: with a nonzero divider, steps are never on adjacent clocks
  assert_prescale_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_q != '0) && !any_wr) |=> !tick);

  // R6: reaching zero in stop-at-zero mode leaves the channel halted at zero
  assert_zero_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_zero && !wr_ctl && !wr_cnt) |=> (halt_q && (cnt_q == '0)));

  // R7: a compare hit halts the channel unless software rewrites control
  assert_match_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|match_evt) && !wr_ctl) |=> halt_q);

  // R8: free-run mode never halts by itself
  assert_free_no_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (kind == TERM_FREE) && !wr_ctl) |=> !halt_q);

endmodule

// File: rtl/mct_irq.sv
module mct_irq #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic             ack_wr,
  input  logic             ena_wr,
  input  logic [N_SRC-1:0] wval,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] enables,
  output logic             irq
);

  function automatic logic [N_SRC-1:0] flag_update(input logic [N_SRC-1:0] cur,
                                                   input logic [N_SRC-1:0] clr,
                                                   input logic [N_SRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [N_SRC-1:0] flag_q, ena_q, clr_vec;

  assign clr_vec = ack_wr ? wval : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      ena_q  <= '0;
    end else begin
      flag_q <= flag_update(flag_q, clr_vec, set_vec);
      if (ena_wr) ena_q <= wval;
    end
  end

  assign flags   = flag_q;
  assign enables = ena_q;
  assign irq     = |(flag_q & ena_q);

  // R9: a flag not named in a clear stays set
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  // R11: an arriving event wins over a clear in the same cycle
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R10: clearing every flag with no new event drops the interrupt
  assert_irq_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ((wval & flag_q) == flag_q) && (set_vec == '0)) |=> !irq);

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer #(
  parameter int N_CH    = 2,
  parameter int N_MATCH = 6,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_irq_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int MODE_W     = $clog2(N_MATCH + 2);
  localparam int UP_BIT     = MODE_W;
  localparam int HALT_BIT   = MODE_W + 1;
  localparam int CH_BYTES   = 12;
  localparam int CMP_BASE   = N_CH * CH_BYTES;
  localparam int OFF_DIV    = 4;
  localparam int OFF_CTL    = 8;
  localparam int OFF_FLAGS  = 0;
  localparam int OFF_ENA    = 4;

  logic tmr_wr, irq_wr;
  assign tmr_wr = reg_we && !reg_irq_sel;
  assign irq_wr = reg_we &&  reg_irq_sel;

  logic [N_MATCH-1:0][CNT_W-1:0] cmp_q;
  logic [N_CH-1:0][CNT_W-1:0]    ch_cnt;
  logic [N_CH-1:0][DIV_W-1:0]    ch_div;
  logic [N_CH-1:0]               ch_halt, ch_up;
  logic [N_CH-1:0][MODE_W-1:0]   ch_mode;
  logic [N_CH-1:0][N_MATCH-1:0]  ch_evt;
  logic [N_MATCH-1:0]            set_vec, flags, enables;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(c * CH_BYTES);
    localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(c * CH_BYTES + OFF_DIV);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(c * CH_BYTES + OFF_CTL);

    mct_channel #(
      .CNT_W(CNT_W), .DIV_W(DIV_W), .N_MATCH(N_MATCH), .MODE_W(MODE_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cnt    (tmr_wr && (reg_addr == A_CNT)),
      .wr_div    (tmr_wr && (reg_addr == A_DIV)),
      .wr_ctl    (tmr_wr && (reg_addr == A_CTL)),
      .wval_cnt  (reg_wdata[CNT_W-1:0]),
      .wval_div  (reg_wdata[DIV_W-1:0]),
      .wval_halt (reg_wdata[HALT_BIT]),
      .wval_up   (reg_wdata[UP_BIT]),
      .wval_mode (reg_wdata[MODE_W-1:0]),
      .cmp_bank  (cmp_q),
      .cnt       (ch_cnt[c]),
      .div       (ch_div[c]),
      .halted    (ch_halt[c]),
      .count_up  (ch_up[c]),
      .mode      (ch_mode[c]),
      .match_evt (ch_evt[c])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int c = 0; c < N_CH; c++) set_vec = set_vec | ch_evt[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else begin
      for (int n = 0; n < N_MATCH; n++)
        if (tmr_wr && (reg_addr == ADDR_W'(CMP_BASE + 4 * n)))
          cmp_q[n] <= reg_wdata[CNT_W-1:0];
    end
  end

  mct_irq #(.N_SRC(N_MATCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .ack_wr  (irq_wr && (reg_addr == ADDR_W'(OFF_FLAGS))),
    .ena_wr  (irq_wr && (reg_addr == ADDR_W'(OFF_ENA))),
    .wval    (reg_wdata[N_MATCH-1:0]),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_irq_sel) begin
      if (reg_addr == ADDR_W'(OFF_FLAGS)) reg_rdata = DATA_W'(flags);
      else if (reg_addr == ADDR_W'(OFF_ENA)) reg_rdata = DATA_W'(enables);
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (reg_addr == ADDR_W'(c * CH_BYTES)) reg_rdata = DATA_W'(ch_cnt[c]);
        if (reg_addr == ADDR_W'(c * CH_BYTES + OFF_DIV)) reg_rdata = DATA_W'(ch_div[c]);
        if (reg_addr == ADDR_W'(c * CH_BYTES + OFF_CTL))
          reg_rdata = DATA_W'({ch_halt[c], ch_up[c], ch_mode[c]});
      end
      for (int n = 0; n < N_MATCH; n++)
        if (reg_addr == ADDR_W'(CMP_BASE + 4 * n)) reg_rdata = DATA_W'(cmp_q[n]);
    end
  end

  // R1: the interrupt is low in the first cycle after reset
  assert_irq_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: tb/tb_dual_match_timer.sv
`timescale 1ns/1ps
module tb_dual_match_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, sel = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  dual_match_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_irq_sel(sel),
    .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt[2], m_div[2], m_pc[2], m_mode[2], m_stop[2], m_up[2];
  int m_cmp[6];
  int m_flag, m_ena;

  function automatic int mdl_read(input bit s, input int a);
    if (s) return (a == 0) ? m_flag : (a == 4) ? m_ena : 0;
    for (int c = 0; c < 2; c++) begin
      if (a == 12*c)     return m_cnt[c];
      if (a == 12*c + 4) return m_div[c];
      if (a == 12*c + 8) return m_stop[c]*16 + m_up[c]*8 + m_mode[c];
    end
    for (int n = 0; n < 6; n++) if (a == 24 + 4*n) return m_cmp[n];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_div[c] = 0; m_pc[c] = 0; m_mode[c] = 0; m_stop[c] = 1; m_up[c] = 0;
      end
      for (int n = 0; n < 6; n++) m_cmp[n] = 0;
      m_flag = 0; m_ena = 0;
    end else begin
      int events;
      int a;
      events = 0;
      a = int'(addr);
      for (int c = 0; c < 2; c++) begin
        bit running, steps, touched;
        int nxt;
        running = (m_stop[c] == 0);
        steps   = running && (m_pc[c] == m_div[c]);
        touched = we && !sel && (a == 12*c || a == 12*c + 4 || a == 12*c + 8);
        if (steps) begin
          if (m_mode[c] == 0 && m_cnt[c] == 0) m_stop[c] = 1;
          else begin
            nxt = m_up[c] ? (m_cnt[c] + 1) % 65536 : (m_cnt[c] + 65535) % 65536;
            m_cnt[c] = nxt;
            if (m_mode[c] == 0 && nxt == 0) m_stop[c] = 1;
            if (m_mode[c] >= 1 && m_mode[c] <= 6 && nxt == m_cmp[m_mode[c]-1]) begin
              m_stop[c] = 1;
              events = events | (1 << (m_mode[c]-1));
            end
          end
        end
        m_pc[c] = (!running || steps || touched) ? 0 : m_pc[c] + 1;
        if (we && !sel && a == 12*c)     m_cnt[c] = wd[15:0];
        if (we && !sel && a == 12*c + 4) m_div[c] = wd[15:0];
        if (we && !sel && a == 12*c + 8) begin
          m_stop[c] = wd[4]; m_up[c] = wd[3]; m_mode[c] = wd[2:0];
        end
      end
      for (int n = 0; n < 6; n++) if (we && !sel && a == 24 + 4*n) m_cmp[n] = wd[15:0];
      if (we && sel && a == 0) m_flag = m_flag & ~int'(wd[5:0]);
      if (we && sel && a == 4) m_ena = wd[5:0];
      m_flag = m_flag | events;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int exp_rd;
      bit exp_irq;
      exp_rd  = mdl_read(sel, int'(addr));
      exp_irq = (m_flag & m_ena) != 0;
      vectors++;
      if (rdata !== 32'(exp_rd) || irq !== exp_irq) begin
        miscompares++;
        $display("FAIL %s model compare: rdata=%h irq=%b expected rdata=%h irq=%b",
                 phase, rdata, irq, exp_rd, exp_irq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit s, input int a, input int d);
    @(negedge clk);
    we = 1'b1; sel = s; addr = 6'(a); wd = 32'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 1'b0;
    end
  endtask

  task automatic rd_chk(input bit s, input int a, input int exp, input string tag);
    @(negedge clk);
    we = 1'b0; sel = s; addr = 6'(a);
    #2;
    chk(tag, int'(rdata), exp);
  endtask

  // run a channel-0 pattern: load, start, wait, halt, read the count
  task automatic run_ch0(input int load, input int ctl, input int waitn, input int exp, input string tag);
    wr(0, 0, load);
    wr(0, 8, ctl);
    idle(waitn);
    wr(0, 8, 'h10);
    rd_chk(0, 0, exp, tag);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1";
    rd_chk(0, 8,  'h10, "R1 ctl0");
    rd_chk(0, 20, 'h10, "R1 ctl1");
    rd_chk(0, 0,  0,    "R1 cnt0");
    rd_chk(1, 0,  0,    "R1 flags");
    chk("R1 irq", int'(irq), 0);

    phase = "R2";
    wr(0, 32, 'h1234);
    rd_chk(0, 32, 'h1234, "R2 compare slot 2");
    wr(0, 16, 5);
    rd_chk(0, 16, 5, "R2 div1");
    wr(0, 16, 0);
    wr(0, 12, 'hBEEF);
    rd_chk(0, 12, 'hBEEF, "R2 cnt1");

    phase = "R3";
    wr(0, 0, 5);
    idle(10);
    rd_chk(0, 0, 5, "R3 halted count holds");

    phase = "R4";
    run_ch0(100, 'h0F, 9, 110, "R4 count up");
    run_ch0(100, 'h07, 9, 90,  "R4 count down");

    phase = "R5";
    wr(0, 4, 3);
    run_ch0(0, 'h0F, 11, 3, "R5 divider 3");
    wr(0, 4, 0);

    phase = "R8";
    run_ch0('hFFFE, 'h0F, 3, 2,       "R8 wrap up");
    run_ch0(1,      'h07, 2, 'hFFFE,  "R8 wrap down");

    phase = "R6";
    wr(0, 0, 3);
    wr(0, 8, 'h00);
    idle(10);
    rd_chk(0, 8, 'h10, "R6 halt bit set");
    rd_chk(0, 0, 0,    "R6 count at zero");

    phase = "R7";
    wr(0, 36, 'h40);
    wr(0, 12, 'h3C);
    wr(0, 20, 'h0C);
    idle(10);
    rd_chk(0, 20, 'h1C, "R7 ch1 halted");
    rd_chk(0, 12, 'h40, "R7 ch1 count");
    rd_chk(1, 0,  'h08, "R7 flag bit 3");
    chk("R10 masked irq low", int'(irq), 0);

    phase = "R10";
    wr(1, 4, 'h01);
    rd_chk(1, 4, 'h01, "R10 enable readback");
    chk("R10 other enable irq low", int'(irq), 0);
    wr(1, 4, 'h08);
    rd_chk(1, 0, 'h08, "R10 flag");
    chk("R10 irq high", int'(irq), 1);

    phase = "R9";
    wr(1, 0, 'h01);
    rd_chk(1, 0, 'h08, "R9 other bit clear ignored");
    wr(1, 0, 'h08);
    rd_chk(1, 0, 0, "R9 flag cleared");
    chk("R9 irq low", int'(irq), 0);

    phase = "R11";
    wr(0, 24, 5);
    wr(0, 0, 9);
    wr(0, 8, 'h01);
    idle(3);
    wr(1, 0, 'h01);
    rd_chk(1, 0, 'h01, "R11 event beats clear");
    rd_chk(0, 8, 'h11, "R11 channel halted on hit");
    wr(1, 0, 'h01);

    phase = "R12";
    wr(0, 0, 9);
    wr(0, 8, 'h01);
    idle(3);
    wr(0, 8, 'h01);
    rd_chk(0, 8, 'h01, "R12 control write beats hw halt");
    wr(0, 8, 'h10);
    rd_chk(1, 0, 'h01, "R12 flag still set");
    wr(1, 0, 'h01);
    wr(0, 8, 'h0F);
    idle(2);
    wr(0, 0, 'h200);
    wr(0, 8, 'h10);
    rd_chk(0, 0, 'h201, "R12 count load beats step");

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule